// File: doc/BRIEF.md
# Debug Instruction and Data Transfer Chains

This block sits behind a debug chain selector in the TCK clock domain. It provides two data-register scan chains for a debug host. The instruction chain lets the host load a 32-bit instruction word for a core. The data chain moves 32-bit words between the host and the core through two mailboxes: one from the host to the core and one from the core to the host. A Ready flag, sampled at every capture, decides whether an update may write. The loaded instruction is issued to the core exactly once each time the TAP enters Run-Test/Idle.

On the core side the block presents the instruction word with a one-cycle issue pulse. The core stub answers with a completion pulse. It drains the host-to-core mailbox with a take strobe and fills the core-to-host mailbox with a write strobe. The TAP controller drives single-cycle capture, shift and update strobes, a level that is high while the TAP sits in Run-Test/Idle, and the serial input.

Two selection codes steer the block: a chain number and a 2-bit instruction-register class.

Named states:
- Scan sequencer (one per chain): `SQ_IDLE` (no capture seen), `SQ_ARMED` (captured) and `SQ_SHIFT` (shifting).
  - Transitions: capture → `SQ_ARMED`; shift in `SQ_ARMED` → `SQ_SHIFT`; update, or loss of selection → `SQ_IDLE`.
- Issue controller: `IS_EMPTY` (no instruction loaded), `IS_LOADED` (instruction held, Ready high) and `IS_BUSY` (issued, Ready low).
  - Transitions: accepted update → `IS_LOADED`; qualified idle entry → `IS_BUSY`; core completion → `IS_LOADED`.

Top module: `dbg_xfer_chains`

## Requirements
- R1: After reset `instr_issue`, `h2c_full` and `c2h_valid` are 0. An idle entry issues nothing until an instruction has been loaded, and a capture of the instruction chain reports Ready = 1.
- R2: Scan chains shift LSB first from `tdi` toward `tdo`; `tdo` is bit 0 of the selected chain. The instruction chain is 33 bits: bits 31..0 are the instruction and bit 32 is Ready. A capture loads zeros into bits 31..0 and the current Ready into bit 32.
- R3: An update of the instruction chain copies bits 31..0 into `instr_word` only if a capture of that chain preceded it and Ready was 1 at that capture. An update with no capture since the last update is ignored.
- R4: `instr_issue` pulses for one cycle, one cycle after the first cycle with `in_idle` high. Issue requires all three of the following: an instruction is loaded, Ready is 1, and `exec_en` is 1. It also requires either of two selections: the instruction or data chain is selected with class 1 or 2, or the class is 3. Staying in idle issues nothing more.
- R5: Ready clears when an instruction issues and returns to 1 at the cycle after `core_done`. An update of the instruction chain whose capture saw Ready = 0 leaves `instr_word` unchanged.
- R6: The data chain is 34 bits: bits 31..0 are data, bit 32 is Ready and bit 33 is nRetry. Under class 1 (write), a capture reports Ready = not `h2c_full`. The following update writes `h2c_word` and sets `h2c_full` only if that Ready was 1. `h2c_take` clears `h2c_full`.
- R7: Under class 2 (read), a capture of the data chain loads the core-to-host word into bits 31..0 and `c2h_valid` into Ready, and clears `c2h_valid`. `c2h_wr` stores `c2h_data` and sets `c2h_valid` only when `c2h_valid` is 0.
- R8: The nRetry bit (data chain bit 33) captures the instruction Ready flag, in both write and read class.
- R9: The instruction chain is selected by chain number 4 with class 1 or 2, or by class 3 with any chain number. The data chain is selected by chain number 5 with class 1 or 2. With neither selected, `tdo` is 0 and strobes change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | TCK clock |
| rst_n | input | 1 | Active-low reset |
| chain_sel | input | 5 | Chain number from the selector |
| ir_op | input | 2 | IR class: 0 other, 1 write, 2 read, 3 instruction select |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| in_idle | input | 1 | High while TAP is in Run-Test/Idle |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| exec_en | input | 1 | Instruction execution enable from the status register |
| core_done | input | 1 | Core completion pulse |
| h2c_take | input | 1 | Core consumes the host-to-core word |
| c2h_wr | input | 1 | Core writes the core-to-host word |
| c2h_data | input | 32 | Core-to-host data |
| instr_word | output | 32 | Loaded instruction |
| instr_issue | output | 1 | One-cycle issue pulse |
| h2c_word | output | 32 | Host-to-core data |
| h2c_full | output | 1 | Host-to-core word pending |
| c2h_valid | output | 1 | Core-to-host word pending |

## Verification
The hardest situation to reach is an update of the instruction chain while the core is still busy, because Ready is low only between an issue and the completion pulse. The bench core stub is given a long, programmable latency. The stimulus then issues once, and within that latency window captures both chains and shifts a new instruction. Through the ports this shows that Ready and nRetry read 0 and that `instr_word` keeps its old value. A second hard case is an update preceded by shifts but no capture: the stimulus shifts a full word without a capture strobe and then updates.

// File: rtl/dbg_xfer_pkg.sv
package dbg_xfer_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_ISEL  = 2'd3
    } xfer_op_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ARMED = 2'd1,
        SQ_SHIFT = 2'd2
    } scan_seq_e;

    typedef enum logic [1:0] {
        IS_EMPTY  = 2'd0,
        IS_LOADED = 2'd1,
        IS_BUSY   = 2'd2
    } issue_st_e;
endpackage

// File: rtl/dbg_xfer_decode.sv
module dbg_xfer_decode
    import dbg_xfer_pkg::*;
#(
    parameter int CHAIN_W = 5,
    parameter int ITR_ID  = 4,
    parameter int DTR_ID  = 5
) (
    input  logic [CHAIN_W-1:0] chain_sel,
    input  logic [1:0]         ir_op,
    output logic               sel_itr,
    output logic               sel_dtr,
    output logic               dtr_rd
);
    xfer_op_e op;
    logic     rw_op;

    always_comb begin
        op      = xfer_op_e'(ir_op);
        rw_op   = (op == OP_WRITE) || (op == OP_READ);
        sel_itr = (op == OP_ISEL) ||
                  (rw_op && (chain_sel == CHAIN_W'(ITR_ID)));
        sel_dtr = rw_op && (chain_sel == CHAIN_W'(DTR_ID));
        dtr_rd  = (op == OP_READ);
    end
endmodule

// File: rtl/dbg_scan_seq.sv
module dbg_scan_seq
    import dbg_xfer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic capture,
    input  logic shift,
    input  logic update,
    output logic upd_ok
);
    scan_seq_e st, nxt;

    always_comb begin
        nxt = st;
        unique case (st)
            SQ_IDLE: begin
                if (sel && capture) nxt = SQ_ARMED;
            end
            SQ_ARMED: begin
                if (!sel || update)  nxt = SQ_IDLE;
                else if (capture)    nxt = SQ_ARMED;
                else if (shift)      nxt = SQ_SHIFT;
            end
            SQ_SHIFT: begin
                if (!sel || update)  nxt = SQ_IDLE;
                else if (capture)    nxt = SQ_ARMED;
            end
            default: nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SQ_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        upd_ok = sel && update && (st != SQ_IDLE);
    end

    p_upd_after_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_ok |-> $past(sel));
endmodule

// File: rtl/dbg_itr_chain.sv
module dbg_itr_chain
    import dbg_xfer_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          issue_arm,
    input  logic          capture,
    input  logic          shift,
    input  logic          update,
    input  logic          tdi,
    input  logic          in_idle,
    input  logic          exec_en,
    input  logic          core_done,
    output logic          so,
    output logic [DW-1:0] instr_word,
    output logic          instr_issue,
    output logic          itr_ready
);
    localparam int LEN = DW + 1;

    logic [LEN-1:0] sr;
    logic           cap_rdy;
    logic           upd_ok;
    logic           idle_q;
    logic           idle_entry;
    logic           fire;
    logic           load;
    issue_st_e      st, nxt;

    dbg_scan_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .capture (capture),
        .shift   (shift),
        .update  (update),
        .upd_ok  (upd_ok)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr      <= '0;
            cap_rdy <= 1'b0;
        end else if (sel && capture) begin
            sr      <= {itr_ready, {DW{1'b0}}};
            cap_rdy <= itr_ready;
        end else if (sel && shift) begin
            sr      <= {tdi, sr[LEN-1:1]};
        end
    end

    always_comb begin
        idle_entry = in_idle && !idle_q;
        load       = upd_ok && cap_rdy;
        fire       = idle_entry && issue_arm && exec_en && (st == IS_LOADED);
    end

    always_comb begin
        nxt = st;
        unique case (st)
            IS_EMPTY:  if (load)      nxt = IS_LOADED;
            IS_LOADED: if (fire)      nxt = IS_BUSY;
            IS_BUSY:   if (core_done) nxt = IS_LOADED;
            default:                  nxt = IS_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= IS_EMPTY;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q      <= 1'b0;
            instr_issue <= 1'b0;
            instr_word  <= '0;
        end else begin
            idle_q      <= in_idle;
            instr_issue <= fire;
            if (load) instr_word <= sr[DW-1:0];
        end
    end

    always_comb begin
        itr_ready = (st != IS_BUSY);
        so        = sr[0];
    end

    p_issue_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        instr_issue |=> !instr_issue);
    p_issue_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        instr_issue |-> ($past(exec_en) && $past(in_idle)));
    p_ready_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(itr_ready) |-> $past(core_done));
    p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == IS_BUSY && $past(st == IS_BUSY)) |-> $stable(instr_word));
endmodule

// File: rtl/dbg_dtr_chain.sv
module dbg_dtr_chain
    import dbg_xfer_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          rd_mode,
    input  logic          capture,
    input  logic          shift,
    input  logic          update,
    input  logic          tdi,
    input  logic          itr_ready,
    input  logic          h2c_take,
    input  logic          c2h_wr,
    input  logic [DW-1:0] c2h_data,
    output logic          so,
    output logic [DW-1:0] h2c_word,
    output logic          h2c_full,
    output logic          c2h_valid
);
    localparam int LEN = DW + 2;

    logic [LEN-1:0] sr;
    logic [DW-1:0]  c2h_q;
    logic           cap_rdy;
    logic           upd_ok;
    logic           cap;

    dbg_scan_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .capture (capture),
        .shift   (shift),
        .update  (update),
        .upd_ok  (upd_ok)
    );

    always_comb cap = sel && capture;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr      <= '0;
            cap_rdy <= 1'b0;
        end else if (cap) begin
            if (rd_mode) begin
                sr      <= {itr_ready, c2h_valid, c2h_q};
                cap_rdy <= c2h_valid;
            end else begin
                sr      <= {itr_ready, !h2c_full, {DW{1'b0}}};
                cap_rdy <= !h2c_full;
            end
        end else if (sel && shift) begin
            sr <= {tdi, sr[LEN-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h2c_word <= '0;
            h2c_full <= 1'b0;
        end else if (upd_ok && !rd_mode && cap_rdy) begin
            h2c_word <= sr[DW-1:0];
            h2c_full <= 1'b1;
        end else if (h2c_take) begin
            h2c_full <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c2h_q     <= '0;
            c2h_valid <= 1'b0;
        end else if (cap && rd_mode && c2h_valid) begin
            c2h_valid <= 1'b0;
        end else if (c2h_wr && !c2h_valid) begin
            c2h_q     <= c2h_data;
            c2h_valid <= 1'b1;
        end
    end

    always_comb so = sr[0];

    p_full_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(h2c_full) |-> $past(update && sel && !rd_mode));
    p_c2h_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (c2h_valid && $past(c2h_valid)) |-> $stable(c2h_q));
endmodule

// File: rtl/dbg_xfer_chains.sv
module dbg_xfer_chains
    import dbg_xfer_pkg::*;
#(
    parameter int DW      = 32,
    parameter int CHAIN_W = 5,
    parameter int ITR_ID  = 4,
    parameter int DTR_ID  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CHAIN_W-1:0] chain_sel,
    input  logic [1:0]         ir_op,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               update_dr,
    input  logic               in_idle,
    input  logic               tdi,
    output logic               tdo,
    input  logic               exec_en,
    input  logic               core_done,
    input  logic               h2c_take,
    input  logic               c2h_wr,
    input  logic [DW-1:0]      c2h_data,
    output logic [DW-1:0]      instr_word,
    output logic               instr_issue,
    output logic [DW-1:0]      h2c_word,
    output logic               h2c_full,
    output logic               c2h_valid
);
    logic sel_itr, sel_dtr, dtr_rd;
    logic so_itr, so_dtr;
    logic itr_ready;

    dbg_xfer_decode #(
        .CHAIN_W (CHAIN_W),
        .ITR_ID  (ITR_ID),
        .DTR_ID  (DTR_ID)
    ) u_dec (
        .chain_sel (chain_sel),
        .ir_op     (ir_op),
        .sel_itr   (sel_itr),
        .sel_dtr   (sel_dtr),
        .dtr_rd    (dtr_rd)
    );

    dbg_itr_chain #(.DW(DW)) u_itr (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel_itr),
        .issue_arm   (sel_itr || sel_dtr),
        .capture     (capture_dr),
        .shift       (shift_dr),
        .update      (update_dr),
        .tdi         (tdi),
        .in_idle     (in_idle),
        .exec_en     (exec_en),
        .core_done   (core_done),
        .so          (so_itr),
        .instr_word  (instr_word),
        .instr_issue (instr_issue),
        .itr_ready   (itr_ready)
    );

    dbg_dtr_chain #(.DW(DW)) u_dtr (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel_dtr),
        .rd_mode   (dtr_rd),
        .capture   (capture_dr),
        .shift     (shift_dr),
        .update    (update_dr),
        .tdi       (tdi),
        .itr_ready (itr_ready),
        .h2c_take  (h2c_take),
        .c2h_wr    (c2h_wr),
        .c2h_data  (c2h_data),
        .so        (so_dtr),
        .h2c_word  (h2c_word),
        .h2c_full  (h2c_full),
        .c2h_valid (c2h_valid)
    );

    always_comb begin
        if (sel_itr)      tdo = so_itr;
        else if (sel_dtr) tdo = so_dtr;
        else              tdo = 1'b0;
    end

    p_tdo_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_sel != CHAIN_W'(ITR_ID) && chain_sel != CHAIN_W'(DTR_ID) && ir_op != 2'd3)
        |-> !tdo);
endmodule

// File: tb/sim_dbg_xfer_chains.sv
module sim_dbg_xfer_chains;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  chain_sel = '0;
    logic [1:0]  ir_op = '0;
    logic        capture_dr = 0, shift_dr = 0, update_dr = 0, in_idle = 0, tdi = 0;
    logic        tdo;
    logic        exec_en = 1'b1;
    logic        core_done;
    logic        h2c_take = 0, c2h_wr = 0;
    logic [31:0] c2h_data = '0;
    logic [31:0] instr_word, h2c_word;
    logic        instr_issue, h2c_full, c2h_valid;

    int errors = 0;
    int checks = 0;
    logic [7:0] lat = 8'd3;
    logic [7:0] cnt;

    always #2 clk = ~clk;

    dbg_xfer_chains u0 (
        .clk(clk), .rst_n(rst_n), .chain_sel(chain_sel), .ir_op(ir_op),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .in_idle(in_idle), .tdi(tdi), .tdo(tdo), .exec_en(exec_en),
        .core_done(core_done), .h2c_take(h2c_take), .c2h_wr(c2h_wr),
        .c2h_data(c2h_data), .instr_word(instr_word), .instr_issue(instr_issue),
        .h2c_word(h2c_word), .h2c_full(h2c_full), .c2h_valid(c2h_valid)
    );

    // core model: completes an issued instruction after lat cycles
    always @(posedge clk) begin
        if (!rst_n)           cnt <= 8'd0;
        else if (instr_issue) cnt <= lat;
        else if (cnt != 0)    cnt <= cnt - 8'd1;
    end
    assign core_done = (cnt == 8'd1);

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic scan(input logic [33:0] din, input int n, input bit do_cap, output logic [33:0] dout);
        dout = '0;
        if (do_cap) begin capture_dr = 1; step(); capture_dr = 0; end
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo; tdi = din[i]; shift_dr = 1; step();
        end
        shift_dr = 0; tdi = 0; update_dr = 1; step(); update_dr = 0;
    endtask

    task automatic t_reset();
        logic [33:0] d;
        chk(instr_issue == 0 && h2c_full == 0 && c2h_valid == 0, "R1 reset flags",
            {instr_issue, h2c_full, c2h_valid}, 0);
        chain_sel = 5'd4; ir_op = 2'd1;
        in_idle = 1; step();
        chk(instr_issue == 0, "R1 no issue when empty", instr_issue, 0);
        in_idle = 0; step();
        scan(34'h0, 33, 1, d);
        chk(d[32:0] == 33'h1_0000_0000, "R2 capture zeros and ready", d[32:0], 33'h1_0000_0000);
    endtask

    task automatic t_itr_load();
        logic [33:0] d;
        chain_sel = 5'd4; ir_op = 2'd1;
        scan({2'b00, 32'hA5A5_1234}, 33, 1, d);
        chk(instr_word == 32'hA5A5_1234, "R3 instruction loaded", instr_word, 32'hA5A5_1234);
        scan({2'b00, 32'h0BAD_0BAD}, 33, 0, d);
        chk(instr_word == 32'hA5A5_1234, "R3 update without capture ignored", instr_word, 32'hA5A5_1234);
    endtask

    task automatic t_issue();
        exec_en = 0; chain_sel = 5'd4; ir_op = 2'd1;
        in_idle = 1; step();
        chk(instr_issue == 0, "R4 exec disabled", instr_issue, 0);
        in_idle = 0; step();
        exec_en = 1; ir_op = 2'd0;
        in_idle = 1; step();
        chk(instr_issue == 0, "R4 not selected", instr_issue, 0);
        in_idle = 0; step();
        chain_sel = 5'd0; ir_op = 2'd3;
        in_idle = 1; step();
        chk(instr_issue == 1, "R4 issue on idle entry", instr_issue, 1);
        begin
            int extra = 0;
            for (int i = 0; i < 5; i++) begin step(); extra += instr_issue; end
            chk(extra == 0, "R4 single issue while in idle", extra, 0);
        end
        in_idle = 0; step(10);
        chain_sel = 5'd5; ir_op = 2'd2;
        in_idle = 1; step();
        chk(instr_issue == 1, "R4 issue with data chain read", instr_issue, 1);
        in_idle = 0; step(10);
    endtask

    task automatic t_busy();
        logic [33:0] d;
        lat = 8'd40;
        chain_sel = 5'd4; ir_op = 2'd1;
        in_idle = 1; step();
        chk(instr_issue == 1, "R5 issue starts busy", instr_issue, 1);
        in_idle = 0; step();
        scan({2'b00, 32'hCCCC_0001}, 33, 1, d);
        chk(d[32] == 0, "R5 ready low while busy", d[32], 0);
        chk(instr_word == 32'hA5A5_1234, "R5 update while busy ignored", instr_word, 32'hA5A5_1234);
        chain_sel = 5'd5; ir_op = 2'd2;
        scan(34'h0, 34, 1, d);
        chk(d[33] == 0, "R8 nretry low while busy", d[33], 0);
        step(45);
        chain_sel = 5'd4; ir_op = 2'd1;
        scan({2'b00, 32'hA5A5_1234}, 33, 1, d);
        chk(d[32] == 1, "R5 ready back after done", d[32], 1);
        chain_sel = 5'd5; ir_op = 2'd2;
        scan(34'h0, 34, 1, d);
        chk(d[33] == 1, "R8 nretry high when idle", d[33], 1);
        lat = 8'd3;
    endtask

    task automatic t_h2c();
        logic [33:0] d;
        chain_sel = 5'd5; ir_op = 2'd1;
        scan({2'b00, 32'hD00D_F00D}, 34, 1, d);
        chk(d[32] == 1, "R6 ready when empty", d[32], 1);
        chk(h2c_full == 1 && h2c_word == 32'hD00D_F00D, "R6 word written",
            h2c_word, 32'hD00D_F00D);
        scan({2'b00, 32'hEEEE_EEEE}, 34, 1, d);
        chk(d[32] == 0, "R6 ready low when full", d[32], 0);
        chk(h2c_word == 32'hD00D_F00D, "R6 write while full ignored", h2c_word, 32'hD00D_F00D);
        h2c_take = 1; step(); h2c_take = 0;
        chk(h2c_full == 0, "R6 take clears full", h2c_full, 0);
    endtask

    task automatic t_c2h();
        logic [33:0] d;
        chk(c2h_valid == 0, "R7 initially empty", c2h_valid, 0);
        c2h_data = 32'h1357_9BDF; c2h_wr = 1; step();
        chk(c2h_valid == 1, "R7 write sets valid", c2h_valid, 1);
        c2h_data = 32'h2468_ACE0; step(); c2h_wr = 0;
        chain_sel = 5'd5; ir_op = 2'd2;
        scan(34'h0, 34, 1, d);
        chk(d[31:0] == 32'h1357_9BDF && d[32] == 1, "R7 capture first word, ready",
            d[32:0], {1'b1, 32'h1357_9BDF});
        chk(c2h_valid == 0, "R7 capture clears valid", c2h_valid, 0);
        scan(34'h0, 34, 1, d);
        chk(d[32] == 0, "R7 ready low when empty", d[32], 0);
    endtask

    task automatic t_unsel();
        logic [33:0] d;
        chain_sel = 5'd2; ir_op = 2'd1;
        scan({2'b11, 32'hFFFF_FFFF}, 34, 1, d);
        chk(d == 34'h0, "R9 tdo quiet", d, 0);
        chk(h2c_full == 0 && c2h_valid == 0 && instr_word == 32'hA5A5_1234,
            "R9 state unchanged", {h2c_full, c2h_valid, instr_word}, {2'b00, 32'hA5A5_1234});
        chain_sel = 5'd4; ir_op = 2'd0;
        scan({2'b00, 32'h5555_AAAA}, 33, 1, d);
        chk(instr_word == 32'hA5A5_1234, "R9 class 0 update ignored", instr_word, 32'hA5A5_1234);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        t_reset();
        t_itr_load();
        t_issue();
        t_busy();
        t_h2c();
        t_c2h();
        t_unsel();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule